// File: doc/BRIEF.md
# Boundary Scan Cell Register

This block is the 48-cell boundary register of an 18-bit bidirectional transceiver with a test port. It sits between the transceiver core and the pads. Each control input has one cell. Each bidirectional data pin has one cell that serves both directions. A test-port controller supplies capture, shift and update strobes and an instruction code. The block loads the cells from the pins or from the core, moves them serially from the test data input to the test data output, and copies them into a shadow stage. In the test instructions it uses those shadow values to override the pad drivers.

The 36 data cells fall into four groups of nine pins: group 0 is cells 0–8, group 1 is cells 9–17, group 2 is cells 18–26 and group 3 is cells 27–35. Groups 0 and 1 are B-side pins and groups 2 and 3 are A-side pins. Cells 36–43 hold the clock and latch-enable controls. Cells 44–47 hold the active-low output enables. Each output-enable cell sets the direction of one data group while a test instruction is in force.

The capture and shift stage works on the rising test-clock edge. The shadow stage loads on the falling edge. Both use a synchronous active-low reset that stands for the controller's reset state.

Top module: `bscan_boundary_reg`

## Requirements
- R1: While `rst_n` is low at a rising edge, shift cells 47..44 become 1 and all other shift cells become 0. While `rst_n` is low at a falling edge, the shadow output-enable cells become 1 and the shadow data cells become 0. After reset, therefore, a test instruction leaves every pad disabled.
- R2: The register is selected when `instr_i` is 1 (sample) or 2 (external test). While it is selected and `shift_en_i` is high, each rising edge loads `tdi_i` into cell 47 and moves every cell down by one position. `tdo_o` always shows cell 0.
- R3: When `cap_en_i` is high with sample selected, cells 47..36 load `pin_ctl_i[11:0]`, where `pin_ctl_i[k]` goes to cell 36+k. Data cell j loads `core_dat_i[j]` if `core_oe_i` is high for its group, and `pin_dat_i[j]` otherwise. Capture takes priority over shift.
- R4: When `cap_en_i` is high with external test selected, every data cell loads `pin_dat_i`, whatever the value of `core_oe_i`.
- R5: At a falling edge where `upd_en_i` is high and the register is selected, the shadow stage copies the shift cells. At any other falling edge it holds its value.
- R6: In external test (code 2), `pad_dat_o` equals the shadow data cells. The output-enable cell for each group is active low: `pad_oe_o[0]` is the inverse of cell 46, `pad_oe_o[1]` of cell 47, `pad_oe_o[2]` of cell 44 and `pad_oe_o[3]` of cell 45.
- R7: In clamp (code 4), the pads are driven from the shadow stage exactly as in R6.
- R8: In high-impedance (code 3), `pad_oe_o` is all zero and `pad_dat_o` follows `core_dat_i`.
- R9: In bypass (code 0, and any unused code 5–7) and in sample, `pad_dat_o` equals `core_dat_i` and `pad_oe_o` equals `core_oe_i`.
- R10: `core_ctl_o` equals `pin_ctl_i`, except that bits 11..8 (the output enables) are forced to 1 in codes 2 and 4.
- R11: In codes 0, 3 and 4, the capture, shift and update strobes leave both the shift stage and the shadow stage unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_i | input | 3 | Instruction code: 0 bypass, 1 sample, 2 external test, 3 high impedance, 4 clamp |
| cap_en_i | input | 1 | Capture strobe |
| shift_en_i | input | 1 | Shift strobe |
| upd_en_i | input | 1 | Update strobe, applied on the falling edge |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out (cell 0) |
| pin_ctl_i | input | 12 | Control pin levels: enables in [11:8], clocks and latch enables in [7:0] |
| pin_dat_i | input | 36 | Levels sensed at the data pads |
| core_dat_i | input | 36 | Core output values toward the pads |
| core_oe_i | input | 4 | Core per-group pad enables, active high |
| core_ctl_o | output | 12 | Control values passed to the core |
| pad_dat_o | output | 36 | Pad driver data |
| pad_oe_o | output | 4 | Pad driver enables per group, active high |

## Verification
A wrong cell value in the shift stage stays hidden until it reaches cell 0. It then appears on `tdo_o` after as many shifts as its distance from cell 0, up to 48 cycles. For that reason the bench reads out the whole register after every capture and after every run of ignored strobes.

A wrong shadow value, or a wrong mapping from output-enable cell to group, shows on `pad_dat_o` or `pad_oe_o`. It appears from the first cycle in which code 2 or 4 is in force. The bench therefore programs mixed enable patterns and changes instruction right after each update.

A mode-decode fault appears at once on the pads or on `core_ctl_o`.

// File: rtl/bsr_pkg.sv
// Shared types and cell-map helpers for the boundary scan cell register.
// Assumes four data groups and four output-enable cells; these follow the
// pin structure and are not tuning knobs.
package bsr_pkg;

    typedef enum logic [2:0] {
        INS_BYPASS = 3'd0,
        INS_SAMPLE = 3'd1,
        INS_EXTEST = 3'd2,
        INS_HIGHZ  = 3'd3,
        INS_CLAMP  = 3'd4
    } instr_e;

    localparam int N_GRP = 4;
    localparam int N_OE  = 4;

    // Offset, above the lowest enable cell, of the enable that owns a group.
    function automatic int oe_slot(input int grp);
        return ((grp < 2) ? 2 : 0) + (grp % 2);
    endfunction

    // The boundary register is in the scan path for these codes only.
    function automatic logic scan_selected(input instr_e ins);
        return (ins == INS_SAMPLE) || (ins == INS_EXTEST);
    endfunction

    // The pads are taken over by the shadow stage for these codes.
    function automatic logic pins_overridden(input instr_e ins);
        return (ins == INS_EXTEST) || (ins == INS_CLAMP);
    endfunction

endpackage

// File: rtl/bsr_shift_stage.sv
// Capture/shift stage of the boundary register, on the rising test clock.
// Chooses a capture source for each data cell (core or pin) from the mode and
// the core's group enable, then shifts from tdi toward cell 0.
// Assumes the controller never raises capture and shift together; capture wins.
module bsr_shift_stage
    import bsr_pkg::*;
#(
    parameter int GRP_W = 9,
    parameter int N_CTL = 8,
    localparam int N_DAT  = N_GRP * GRP_W,
    localparam int N_CELL = N_DAT + N_CTL + N_OE
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sel,
    input  logic                   extest,
    input  logic                   cap_en,
    input  logic                   shift_en,
    input  logic                   tdi,
    input  logic [N_CTL+N_OE-1:0]  pin_ctl_i,
    input  logic [N_DAT-1:0]       pin_dat_i,
    input  logic [N_DAT-1:0]       core_dat_i,
    input  logic [N_GRP-1:0]       core_oe_i,
    output logic [N_CELL-1:0]      sr_q,
    output logic                   tdo
);

    localparam logic [N_CELL-1:0] RST_VAL = {{N_OE{1'b1}}, {(N_CELL-N_OE){1'b0}}};

    logic [N_DAT-1:0] cap_dat;

    // Per data cell: core value when the core drives the pin in sample, pin otherwise.
    for (genvar j = 0; j < N_DAT; j++) begin : g_src
        localparam int G = j / GRP_W;
        assign cap_dat[j] = (!extest && core_oe_i[G]) ? core_dat_i[j] : pin_dat_i[j];
    end

    // Shift stage register: reset, parallel capture, or serial shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= RST_VAL;
        end else if (sel && cap_en) begin
            sr_q <= {pin_ctl_i, cap_dat};
        end else if (sel && shift_en) begin
            sr_q <= {tdi, sr_q[N_CELL-1:1]};
        end
    end

    // Serial output is the lowest cell.
    assign tdo = sr_q[0];

    a_r2_tdo_next: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && shift_en && !cap_en) |=> (tdo == $past(sr_q[1])));

    a_r2_tdi_enters_top: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && shift_en && !cap_en) |=> (sr_q[N_CELL-1] == $past(tdi)));

    a_r11_hold_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable(sr_q));

endmodule

// File: rtl/bsr_shadow_stage.sv
// Shadow stage of the boundary register, loaded on the falling test clock.
// Holds only the cells that reach the pads (output enables and data); the
// clock and latch-enable cells have no shadow since their pins always feed
// the core. Assumes inputs are steady across the falling edge.
module bsr_shadow_stage
    import bsr_pkg::*;
#(
    parameter int N_DAT = 36,
    localparam int N_SHD = N_DAT + N_OE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [N_SHD-1:0] d,
    output logic [N_SHD-1:0] q
);

    localparam logic [N_SHD-1:0] RST_VAL = {{N_OE{1'b1}}, {N_DAT{1'b0}}};

    // Shadow register: reset to disabled outputs, else copy on update.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (load) begin
            q <= d;
        end
    end

    a_r5_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |-> $stable(q));

    a_r5_shadow_copy: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (q == d));

endmodule

// File: rtl/bsr_pin_mux.sv
// Pad and core-control override for the boundary register.
// Normal codes pass the core through. The test codes drive the pads from the
// shadow stage, with each group enabled by its active-low enable cell. The
// high-impedance code turns every pad off. Purely combinational.
module bsr_pin_mux
    import bsr_pkg::*;
#(
    parameter int GRP_W = 9,
    parameter int N_CTL = 8,
    localparam int N_DAT = N_GRP * GRP_W,
    localparam int N_SHD = N_DAT + N_OE
) (
    input  instr_e                 ins,
    input  logic [N_SHD-1:0]       shd,
    input  logic [N_DAT-1:0]       core_dat_i,
    input  logic [N_GRP-1:0]       core_oe_i,
    input  logic [N_CTL+N_OE-1:0]  pin_ctl_i,
    output logic [N_DAT-1:0]       pad_dat_o,
    output logic [N_GRP-1:0]       pad_oe_o,
    output logic [N_CTL+N_OE-1:0]  core_ctl_o
);

    logic [N_GRP-1:0] test_oe;

    // Group enable taken from the group's active-low shadow enable cell.
    for (genvar g = 0; g < N_GRP; g++) begin : g_oe
        assign test_oe[g] = ~shd[N_DAT + oe_slot(g)];
    end

    // Output selection per instruction code.
    always_comb begin
        pad_dat_o  = core_dat_i;
        pad_oe_o   = core_oe_i;
        core_ctl_o = pin_ctl_i;
        if (pins_overridden(ins)) begin
            pad_dat_o = shd[N_DAT-1:0];
            pad_oe_o  = test_oe;
            core_ctl_o[N_CTL+N_OE-1:N_CTL] = '1;
        end else if (ins == INS_HIGHZ) begin
            pad_oe_o = '0;
        end
    end

endmodule

// File: rtl/bscan_boundary_reg.sv
// Boundary scan cell register, top level.
// Wires the capture/shift stage, the shadow stage and the pad override.
// Assumes the test-port controller gives one strobe at a time and holds
// instr_i steady while strobes are active.
module bscan_boundary_reg
    import bsr_pkg::*;
#(
    parameter int GRP_W = 9,
    parameter int N_CTL = 8,
    localparam int N_DAT  = N_GRP * GRP_W,
    localparam int N_CELL = N_DAT + N_CTL + N_OE,
    localparam int OE_LO  = N_DAT + N_CTL,
    localparam int N_SHD  = N_DAT + N_OE
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2:0]            instr_i,
    input  logic                  cap_en_i,
    input  logic                  shift_en_i,
    input  logic                  upd_en_i,
    input  logic                  tdi_i,
    output logic                  tdo_o,
    input  logic [N_CTL+N_OE-1:0] pin_ctl_i,
    input  logic [N_DAT-1:0]      pin_dat_i,
    input  logic [N_DAT-1:0]      core_dat_i,
    input  logic [N_GRP-1:0]      core_oe_i,
    output logic [N_CTL+N_OE-1:0] core_ctl_o,
    output logic [N_DAT-1:0]      pad_dat_o,
    output logic [N_GRP-1:0]      pad_oe_o
);

    instr_e            ins;
    logic              sel;
    logic [N_CELL-1:0] sr_q;
    logic [N_SHD-1:0]  shd_q;

    assign ins = instr_e'(instr_i);
    assign sel = scan_selected(ins);

    bsr_shift_stage #(.GRP_W(GRP_W), .N_CTL(N_CTL)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .extest     (ins == INS_EXTEST),
        .cap_en     (cap_en_i),
        .shift_en   (shift_en_i),
        .tdi        (tdi_i),
        .pin_ctl_i  (pin_ctl_i),
        .pin_dat_i  (pin_dat_i),
        .core_dat_i (core_dat_i),
        .core_oe_i  (core_oe_i),
        .sr_q       (sr_q),
        .tdo        (tdo_o)
    );

    bsr_shadow_stage #(.N_DAT(N_DAT)) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (upd_en_i && sel),
        .d     ({sr_q[N_CELL-1:OE_LO], sr_q[N_DAT-1:0]}),
        .q     (shd_q)
    );

    bsr_pin_mux #(.GRP_W(GRP_W), .N_CTL(N_CTL)) u_mux (
        .ins        (ins),
        .shd        (shd_q),
        .core_dat_i (core_dat_i),
        .core_oe_i  (core_oe_i),
        .pin_ctl_i  (pin_ctl_i),
        .pad_dat_o  (pad_dat_o),
        .pad_oe_o   (pad_oe_o),
        .core_ctl_o (core_ctl_o)
    );

    a_r8_highz_off: assert property (@(posedge clk) disable iff (!rst_n)
        (ins == INS_HIGHZ) |-> (pad_oe_o == '0));

    a_r6_extest_group1_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (ins == INS_EXTEST) |-> (pad_oe_o[1] == !shd_q[N_DAT + 3]));

    a_r7_clamp_data: assert property (@(posedge clk) disable iff (!rst_n)
        (ins == INS_CLAMP) |-> (pad_dat_o == shd_q[N_DAT-1:0]));

    a_r9_normal_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (ins == INS_SAMPLE || ins == INS_BYPASS) |->
            (pad_dat_o == core_dat_i && pad_oe_o == core_oe_i));

    a_r10_ctl_pass: assert property (@(posedge clk) disable iff (!rst_n)
        core_ctl_o[N_CTL-1:0] == pin_ctl_i[N_CTL-1:0]);

endmodule

// File: tb/bscan_boundary_reg_tb_top.sv
// Bench: a behavioural model of the cells is compared with every output
// each cycle. Inputs change 2 ns after the rising edge; outputs are compared 1 ns later.
module bscan_boundary_reg_tb_top;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n, cap, sh, upd, tdi, tdo;
    logic [2:0]  ins;
    logic [11:0] pctl, cctl;
    logic [35:0] pdat, cdat, paddat;
    logic [3:0]  coe, padoe;

    bscan_boundary_reg dut_i (
        .clk(clk), .rst_n(rst_n), .instr_i(ins), .cap_en_i(cap), .shift_en_i(sh),
        .upd_en_i(upd), .tdi_i(tdi), .tdo_o(tdo), .pin_ctl_i(pctl), .pin_dat_i(pdat),
        .core_dat_i(cdat), .core_oe_i(coe), .core_ctl_o(cctl), .pad_dat_o(paddat),
        .pad_oe_o(padoe)
    );

    // Knobs set by the scenario, applied by step().
    logic        k_rst = 1'b0, k_cap = 1'b0, k_sh = 1'b0, k_upd = 1'b0, k_tdi = 1'b0;
    logic [2:0]  k_ins = 3'd0;
    logic [11:0] k_pctl = '0;
    logic [35:0] k_pdat = '0, k_cdat = '0;
    logic [3:0]  k_coe = '0;

    logic [47:0] m_sr, m_shd;
    int    n_cmp = 0, n_bad = 0;
    bit    chk = 1'b0, done = 1'b0;
    string scn = "R1";

    localparam logic [47:0] RSTV = {4'hF, 44'h0};

    task automatic report(string rq, string what, logic [47:0] act, logic [47:0] exp);
        n_bad++;
        $display("FAIL %s [%s] %s act=%h exp=%h", rq, scn, what, act, exp);
    endtask

    task automatic compare();
        logic [35:0] ed;
        logic [3:0]  eo;
        logic [11:0] ec;
        string       mt;
        ec = pctl; ed = cdat; eo = coe; mt = "R9";
        if (ins == 3'd2 || ins == 3'd4) begin
            ec[11:8] = 4'hF;
            ed = m_shd[35:0];
            eo = {~m_shd[45], ~m_shd[44], ~m_shd[47], ~m_shd[46]};
            mt = (ins == 3'd2) ? "R6" : "R7";
        end else if (ins == 3'd3) begin
            eo = 4'h0; mt = "R8";
        end
        n_cmp += 4;
        if (tdo !== m_sr[0])     report(scn, "tdo", 48'(tdo), 48'(m_sr[0]));
        if (paddat !== ed)       report(mt, "pad_dat_o", 48'(paddat), 48'(ed));
        if (padoe !== eo)        report(mt, "pad_oe_o", 48'(padoe), 48'(eo));
        if (cctl !== ec)         report("R10", "core_ctl_o", 48'(cctl), 48'(ec));
    endtask

    task automatic step();
        bit sel;
        #2;
        rst_n = k_rst; ins = k_ins; cap = k_cap; sh = k_sh; upd = k_upd; tdi = k_tdi;
        pctl = k_pctl; pdat = k_pdat; cdat = k_cdat; coe = k_coe;
        sel = (ins == 3'd1 || ins == 3'd2);
        #1;
        if (chk) compare();
        @(negedge clk);
        if (!rst_n) m_shd = RSTV;
        else if (upd && sel) m_shd = m_sr;
        @(posedge clk);
        if (!rst_n) m_sr = RSTV;
        else if (sel && cap) begin
            for (int j = 0; j < 36; j++)
                m_sr[j] = (ins == 3'd1 && coe[j / 9]) ? cdat[j] : pdat[j];
            m_sr[47:36] = pctl;
        end else if (sel && sh) m_sr = {tdi, m_sr[47:1]};
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic shift_rand(int n);
        k_sh = 1'b1;
        for (int i = 0; i < n; i++) begin k_tdi = 1'($urandom()); step(); end
        k_sh = 1'b0;
    endtask

    task automatic shift_pat(logic [47:0] pat);
        k_sh = 1'b1;
        for (int i = 0; i < 48; i++) begin k_tdi = pat[i]; step(); end
        k_sh = 1'b0;
    endtask

    task automatic pulse_cap();
        k_cap = 1'b1; step(); k_cap = 1'b0;
    endtask

    task automatic pulse_upd();
        k_upd = 1'b1; step(); k_upd = 1'b0;
    endtask

    task automatic randomize_pins();
        k_pctl = 12'($urandom());
        k_pdat = 36'({$urandom(), $urandom()});
        k_cdat = 36'({$urandom(), $urandom()});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog (all requirements) act=running exp=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd77));
        m_sr = 'x; m_shd = 'x;
        @(posedge clk);
        // R1: reset, then compare from the cycle after the first reset edge.
        k_rst = 1'b0; k_ins = 3'd2;
        step(); chk = 1'b1; idle(2);
        k_rst = 1'b1; scn = "R1"; idle(2);
        // R1 and R2: read the reset pattern out through tdo.
        scn = "R1/R2 readout"; shift_rand(48);
        // R3: sample capture with mixed core enables, then read out.
        k_ins = 3'd1; k_coe = 4'b0101; randomize_pins(); scn = "R3";
        pulse_cap(); shift_rand(48);
        k_coe = 4'b1010; randomize_pins(); pulse_cap(); shift_rand(48);
        // R5 and R6: load a pattern with mixed enables and update, then external test.
        scn = "R5"; shift_pat({4'b1010, 44'({$urandom(), $urandom()})}); pulse_upd();
        k_ins = 3'd2; scn = "R6"; idle(3);
        shift_pat({4'b0101, 44'({$urandom(), $urandom()})}); pulse_upd(); idle(2);
        // R4: in external test, capture takes pins even when the core enables are high.
        k_coe = 4'hF; randomize_pins(); scn = "R4"; pulse_cap(); shift_rand(48);
        pulse_upd(); idle(2);
        // R7 and R11: clamp drives from the shadow; the strobes are ignored.
        k_ins = 3'd4; scn = "R7/R11"; randomize_pins();
        k_cap = 1'b1; step(); k_cap = 1'b0; shift_rand(5); pulse_upd(); idle(2);
        // R8 and R11: high impedance.
        k_ins = 3'd3; scn = "R8/R11"; randomize_pins();
        pulse_cap(); shift_rand(4); pulse_upd();
        // R9 and R11: bypass and an unused code.
        k_ins = 3'd0; scn = "R9/R11"; k_coe = 4'b0110; randomize_pins();
        pulse_cap(); shift_rand(3); pulse_upd();
        k_ins = 3'd6; pulse_cap(); shift_rand(3); pulse_upd();
        // R11: the shift stage was preserved; read it out in sample mode.
        k_ins = 3'd1; scn = "R11 readout"; shift_rand(48);
        pulse_upd(); k_ins = 3'd2; scn = "R6"; idle(2);
        // R1: reset in the middle of the run, while in external test.
        k_rst = 1'b0; scn = "R1"; idle(2); k_rst = 1'b1; idle(2);
        finish_run();
    end

endmodule